// File: doc/BRIEF.md
# Double-Buffered Four-Wire Serial Transmitter

This block is the transmit side of a clock-synchronous serial port on a four-wire bus: clock, outgoing data, incoming data and chip select. Software puts a word into a holding register. When the shifter is free, the block copies the word into the shifter and starts shifting it out, most significant bit first. The holding register is then free again, so the next word can be written while the current frame is still on the wire. Frame length is chosen per frame, from 8 to 16 bits.

As master, the block drives select low and produces an idle-high clock with a programmable half period. Data changes on falling edges, and the far end samples on rising edges (mode 3). If the next word is in the holding register by the final rising edge of a frame, the next frame follows with select held low. Otherwise the block raises a sticky transmit-end flag, releases select and parks the clock high. As slave, the block shifts on an external clock that is synchronised into the local clock domain, and it does so only while the external select is low.

An overrun flag set by the receive side blocks any new start until software clears it. The holding-empty and transmit-end flags each drive a maskable interrupt line.

Top module: `dbuf_sertx`

## Requirements
- R1: After reset, the holding-empty flag is 1. Transmit-end and overrun are 0. Select and clock outputs are 1.
- R2: An accepted write (write strobe with transmit enable 1 and overrun 0) clears the holding-empty flag at that clock edge. With the shifter idle, the word moves to the shifter on the next edge, which sets the holding-empty flag again and (as master) drives select low.
- R3: Bits leave MSB first from the low `len` bits of the written word. A requested length below 8 is treated as 8, and one above 16 is treated as 16. Upper word bits beyond the length never appear.
- R4: As master, the clock is high whenever select is high. The first falling edge comes CLK_DIV cycles after select falls, and each later half period lasts CLK_DIV cycles. Data is stable on each rising edge.
- R5: If the holding register is full at the frame's last rising edge, its word follows in the next frame with select held low throughout.
- R6: If the holding register is empty at the last rising edge, the transmit-end flag sets and stays set. Select returns high and the clock stays high.
- R7: The transmit-end flag clears on a clear strobe or on an accepted write.
- R8: The empty interrupt is the holding-empty flag ANDed with its enable. The end interrupt is the transmit-end flag ANDed with its enable.
- R9: A write is ignored while transmit enable is 0 or overrun is 1. Overrun sets from the receive-side strobe and clears only on its clear strobe.
- R10: As slave, shifting follows the external clock only while external select is low. The data output enable is 0 while external select is high. Clock and select enables are 0.
- R11: As master, the data output enable equals the select output enable, which is 1 exactly when transmit enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = master, 0 = slave |
| tx_en_i | input | 1 | Transmit enable |
| len_i | input | LW | Requested frame length in bits |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | MAX_LEN | Word to transmit |
| clr_tend_i | input | 1 | Clear transmit-end flag |
| ovr_set_i | input | 1 | Overrun report from the receive side |
| clr_ovr_i | input | 1 | Clear overrun flag |
| tdre_ie_i | input | 1 | Holding-empty interrupt enable |
| tend_ie_i | input | 1 | Transmit-end interrupt enable |
| sck_i | input | 1 | External clock (slave) |
| cs_i | input | 1 | External select, active low (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Clock output enable |
| cs_o | output | 1 | Select out, active low (master) |
| cs_oe_o | output | 1 | Select output enable |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Data output enable |
| tdre_o | output | 1 | Holding register empty |
| tend_o | output | 1 | Transmit end |
| ovr_o | output | 1 | Overrun error |
| txi_o | output | 1 | Holding-empty interrupt |
| tei_o | output | 1 | Transmit-end interrupt |

## Verification
The bench uses CLK_DIV = 2, which gives a 16-bit frame of only 64 cycles. A chained pair of frames and several length cases therefore fit in a short run, and the first falling edge lands exactly two cycles after select drops. MAX_LEN = 16 and MIN_LEN = 8 are kept at their defaults, so both clamps are reached: a requested length of 3 and a requested length of 20. SYNC_STAGES = 2 keeps the slave path latency at three cycles. The bench therefore drives its external clock with six-cycle half periods and samples data just before each rising edge.

// File: rtl/dbuf_sertx_pkg.sv
package dbuf_sertx_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_ev_t;

  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/sertx_mclk.sv
module sertx_mclk
  import dbuf_sertx_pkg::*;
#(
  parameter int DIV = 4,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  output logic    sck_o,
  output sck_ev_t ev_o
);
  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sck_o      = sck_q;
  assign ev_o.rise  = tick & ~sck_q;
  assign ev_o.fall  = tick &  sck_q;
endmodule

// File: rtl/sertx_pin_sync.sv
module sertx_pin_sync
  import dbuf_sertx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sck_i,
  input  logic    cs_i,
  output logic    cs_s_o,
  output sck_ev_t ev_o
);
  logic [STAGES-1:0] sck_sh, cs_sh;
  logic              sck_d;
  logic              sck_s, cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sh <= '1;
      cs_sh  <= '1;
      sck_d  <= 1'b1;
    end else begin
      sck_sh <= {sck_sh[STAGES-2:0], sck_i};
      cs_sh  <= {cs_sh[STAGES-2:0], cs_i};
      sck_d  <= sck_s;
    end
  end

  assign sck_s     = sck_sh[STAGES-1];
  assign cs_s      = cs_sh[STAGES-1];
  assign cs_s_o    = cs_s;
  assign ev_o.rise =  sck_s & ~sck_d & ~cs_s;
  assign ev_o.fall = ~sck_s &  sck_d & ~cs_s;
endmodule

// File: rtl/sertx_shreg.sv
module sertx_shreg
  import dbuf_sertx_pkg::*;
#(
  parameter int MAXL = 16,
  parameter int LW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MAXL-1:0] word_i,
  input  logic [LW-1:0]   len_i,
  input  sck_ev_t         ev_i,
  output logic            sd_o,
  output logic            last_o
);
  logic [MAXL-1:0] sreg_q;
  logic [LW-1:0]   cnt_q, len_q, shamt;
  logic            pend_q;

  assign shamt  = LW'(MAXL) - len_i;
  assign last_o = ev_i.rise && (cnt_q == len_q - LW'(1));
  assign sd_o   = sreg_q[MAXL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      len_q  <= LW'(MAXL);
      pend_q <= 1'b0;
    end else if (load_i) begin
      sreg_q <= word_i << shamt;  // left-align so MSB of frame sits on top
      cnt_q  <= '0;
      len_q  <= len_i;
      pend_q <= 1'b0;
    end else if (ev_i.fall && pend_q) begin
      sreg_q <= sreg_q << 1;
      pend_q <= 1'b0;
    end else if (ev_i.rise) begin
      pend_q <= 1'b1;
      if (!last_o) cnt_q <= cnt_q + LW'(1);
    end
  end
endmodule

// File: rtl/dbuf_sertx.sv
module dbuf_sertx
  import dbuf_sertx_pkg::*;
#(
  parameter int MAX_LEN     = 16,
  parameter int MIN_LEN     = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               master_i,
  input  logic               tx_en_i,
  input  logic [LW-1:0]      len_i,
  input  logic               wr_i,
  input  logic [MAX_LEN-1:0] wr_data_i,
  input  logic               clr_tend_i,
  input  logic               ovr_set_i,
  input  logic               clr_ovr_i,
  input  logic               tdre_ie_i,
  input  logic               tend_ie_i,
  input  logic               sck_i,
  input  logic               cs_i,
  output logic               sck_o,
  output logic               sck_oe_o,
  output logic               cs_o,
  output logic               cs_oe_o,
  output logic               sd_o,
  output logic               sd_oe_o,
  output logic               tdre_o,
  output logic               tend_o,
  output logic               ovr_o,
  output logic               txi_o,
  output logic               tei_o
);
  logic [MAX_LEN-1:0] hold_q;
  logic [LW-1:0]      len_eff;
  logic tdre_q, tend_q, ovr_q, busy_q, pend_load_q;
  logic wr_acc, can_go, idle_load, chain_load, load, last;
  logic m_sck, cs_s;
  sck_ev_t m_ev, s_ev, ev;

  assign len_eff    = LW'(clamp_len(int'(len_i), MIN_LEN, MAX_LEN));
  assign wr_acc     = wr_i & tx_en_i & ~ovr_q;
  assign can_go     = tx_en_i & ~ovr_q & ~tdre_q;
  assign idle_load  = ~busy_q & can_go;
  assign chain_load = pend_load_q & ev.fall;
  assign load       = idle_load | chain_load;

  sertx_mclk #(.DIV(CLK_DIV)) u_mclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q & master_i),
    .sck_o(m_sck), .ev_o(m_ev)
  );

  sertx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_i(cs_i),
    .cs_s_o(cs_s), .ev_o(s_ev)
  );

  always_comb begin
    ev      = master_i ? m_ev : s_ev;
    ev.rise = ev.rise & busy_q;
    ev.fall = ev.fall & busy_q;
  end

  sertx_shreg #(.MAXL(MAX_LEN), .LW(LW)) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .word_i(hold_q),
    .len_i(len_eff), .ev_i(ev), .sd_o(sd_o), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      tdre_q      <= 1'b1;
      tend_q      <= 1'b0;
      ovr_q       <= 1'b0;
      busy_q      <= 1'b0;
      pend_load_q <= 1'b0;
    end else begin
      if (load) tdre_q <= 1'b1;
      if (idle_load) busy_q <= 1'b1;
      if (chain_load) pend_load_q <= 1'b0;
      if (last) begin
        if (can_go) pend_load_q <= 1'b1;   // chain: load on next falling edge
        else begin
          busy_q <= 1'b0;
          tend_q <= 1'b1;
        end
      end
      if (clr_tend_i) tend_q <= 1'b0;
      if (wr_acc) begin
        hold_q <= wr_data_i;
        tdre_q <= 1'b0;
        tend_q <= 1'b0;
      end
      if (ovr_set_i) ovr_q <= 1'b1;
      if (clr_ovr_i) ovr_q <= 1'b0;
    end
  end

  assign sck_o    = master_i ? m_sck : 1'b1;
  assign cs_o     = master_i ? ~busy_q : 1'b1;
  assign cs_oe_o  = master_i & tx_en_i;
  assign sck_oe_o = master_i & tx_en_i;
  assign sd_oe_o  = master_i ? cs_oe_o : ~cs_s;
  assign tdre_o   = tdre_q;
  assign tend_o   = tend_q;
  assign ovr_o    = ovr_q;
  assign txi_o    = tdre_q & tdre_ie_i;
  assign tei_o    = tend_q & tend_ie_i;
endmodule

// File: rtl/dbuf_sertx_chk.sv
module dbuf_sertx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic tx_en_i,
  input logic wr_i,
  input logic clr_tend_i,
  input logic clr_ovr_i,
  input logic sck_o,
  input logic cs_o,
  input logic tdre_o,
  input logic tend_o,
  input logic ovr_o
);
  assert_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (!tx_en_i || ovr_o) && tdre_o) |=> tdre_o);

  assert_ovr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_ovr_i) |=> ovr_o);

  assert_tend_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tend_o && !clr_tend_i && !(wr_i && tx_en_i && !ovr_o)) |=> tend_o);

  assert_idle_clk_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && cs_o) |-> sck_o);

  assert_tend_cs_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && tend_o) |-> cs_o);

  assert_no_start_ovr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && cs_o && ovr_o && $stable(master_i)) |=> cs_o);
endmodule

bind dbuf_sertx dbuf_sertx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .tx_en_i(tx_en_i),
  .wr_i(wr_i), .clr_tend_i(clr_tend_i), .clr_ovr_i(clr_ovr_i),
  .sck_o(sck_o), .cs_o(cs_o), .tdre_o(tdre_o), .tend_o(tend_o), .ovr_o(ovr_o)
);

// File: tb/dbuf_sertx_bench.sv
`timescale 1ns/1ps
module dbuf_sertx_bench;
  localparam int MAXL = 16;
  localparam int LW   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, tx_en = 1'b1, wr = 1'b0, clr_tend = 1'b0;
  logic ovr_set = 1'b0, clr_ovr = 1'b0, tdre_ie = 1'b1, tend_ie = 1'b1;
  logic sck_in = 1'b1, cs_in = 1'b1;
  logic [LW-1:0]   len = 5'd8;
  logic [MAXL-1:0] wdata = '0;
  logic sck, sck_oe, cs, cs_oe, sd, sd_oe, tdre, tend, ovr, txi, tei;

  int checks = 0, errors = 0, cs_rises = 0;

  always #2 clk = ~clk;
  always @(posedge cs) cs_rises++;

  dbuf_sertx #(.MAX_LEN(16), .MIN_LEN(8), .CLK_DIV(2), .SYNC_STAGES(2)) u_dbuf_sertx (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .tx_en_i(tx_en), .len_i(len),
    .wr_i(wr), .wr_data_i(wdata), .clr_tend_i(clr_tend), .ovr_set_i(ovr_set),
    .clr_ovr_i(clr_ovr), .tdre_ie_i(tdre_ie), .tend_ie_i(tend_ie),
    .sck_i(sck_in), .cs_i(cs_in), .sck_o(sck), .sck_oe_o(sck_oe), .cs_o(cs),
    .cs_oe_o(cs_oe), .sd_o(sd), .sd_oe_o(sd_oe), .tdre_o(tdre), .tend_o(tend),
    .ovr_o(ovr), .txi_o(txi), .tei_o(tei)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [MAXL-1:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rx_master(input int n, inout logic [31:0] w);
    for (int i = 0; i < n; i++) begin
      @(posedge sck); #1;
      w = {w[30:0], sd};
    end
  endtask

  task automatic t_reset;
    chk("R1 tdre", 32'(tdre), 1);
    chk("R1 tend", 32'(tend), 0);
    chk("R1 ovr", 32'(ovr), 0);
    chk("R1 cs", 32'(cs), 1);
    chk("R1 sck", 32'(sck), 1);
  endtask

  task automatic t_master_frame(input logic [MAXL-1:0] d, input logic [LW-1:0] l,
                                input int nbits, input string req);
    logic [31:0] w = 0;
    len = l;
    do_write(d);
    chk("R2 tdre cleared", 32'(tdre), 0);
    @(negedge clk);
    chk("R2 tdre reloaded", 32'(tdre), 1);
    chk("R2 cs low", 32'(cs), 0);
    @(negedge clk);
    chk("R4 sck high setup", 32'(sck), 1);
    @(negedge clk);
    chk("R4 first fall", 32'(sck), 0);
    rx_master(nbits, w);
    chk(req, w, 32'(d) & ((32'd1 << nbits) - 1));
    chk("R6 cs high", 32'(cs), 1);
    chk("R6 sck high", 32'(sck), 1);
    chk("R6 tend", 32'(tend), 1);
    chk("R8 tei", 32'(tei), 1);
  endtask

  task automatic t_chain;
    logic [31:0] w = 0;
    len = 5'd8;
    do_write(16'h003C);
    @(negedge clk);
    chk("R2 first load", 32'(tdre), 1);
    do_write(16'h00D2);
    chk("R8 txi low when full", 32'(txi), 0);
    cs_rises = 0;
    rx_master(8, w);
    chk("R5 cs held", 32'(cs), 0);
    chk("R5 no cs pulse", 32'(cs_rises), 0);
    chk("R5 tend not set", 32'(tend), 0);
    rx_master(8, w);
    chk("R5 chained data", w & 32'hFFFF, 32'h3CD2);
    chk("R6 tend after chain", 32'(tend), 1);
    chk("R6 one cs rise", 32'(cs_rises), 1);
  endtask

  task automatic t_tend_clear;
    @(negedge clk); clr_tend = 1'b1;
    @(negedge clk); clr_tend = 1'b0;
    chk("R7 clr strobe", 32'(tend), 0);
    t_master_frame(16'h0081, 5'd8, 8, "R3 frame 81");
    do_write(16'h0011);
    chk("R7 write clears", 32'(tend), 0);
    wait (tend === 1'b1);
    @(negedge clk);
  endtask

  task automatic t_irq;
    tdre_ie = 1'b0; tend_ie = 1'b0; #1;
    chk("R8 txi masked", 32'(txi), 0);
    chk("R8 tei masked", 32'(tei), 0);
    tdre_ie = 1'b1; #1;
    chk("R8 txi", 32'(txi), 1);
    tend_ie = 1'b1;
  endtask

  task automatic t_lockout;
    tx_en = 1'b0;
    do_write(16'h00FF);
    @(negedge clk);
    chk("R9 disabled write", 32'(tdre), 1);
    chk("R9 disabled no start", 32'(cs), 1);
    tx_en = 1'b1;
    @(negedge clk); ovr_set = 1'b1;
    @(negedge clk); ovr_set = 1'b0;
    chk("R9 ovr set", 32'(ovr), 1);
    do_write(16'h00FF);
    repeat (3) @(negedge clk);
    chk("R9 ovr write ignored", 32'(tdre), 1);
    chk("R9 ovr no start", 32'(cs), 1);
    chk("R9 ovr sticky", 32'(ovr), 1);
    clr_ovr = 1'b1;
    @(negedge clk); clr_ovr = 1'b0;
    chk("R9 ovr cleared", 32'(ovr), 0);
  endtask

  task automatic t_oe_master;
    master = 1'b1; tx_en = 1'b1; #1;
    chk("R11 sd_oe on", 32'(sd_oe), 1);
    chk("R11 cs_oe on", 32'(cs_oe), 1);
    tx_en = 1'b0; #1;
    chk("R11 sd_oe off", 32'(sd_oe), 0);
    chk("R11 cs_oe off", 32'(cs_oe), 0);
    tx_en = 1'b1;
  endtask

  task automatic t_slave;
    logic [31:0] w = 0;
    master = 1'b0; cs_in = 1'b1; sck_in = 1'b1; len = 5'd8;
    repeat (4) @(negedge clk);
    chk("R10 sd_oe idle", 32'(sd_oe), 0);
    chk("R10 cs_oe", 32'(cs_oe), 0);
    chk("R10 sck_oe", 32'(sck_oe), 0);
    do_write(16'h00B4);
    @(negedge clk);
    chk("R10 loaded", 32'(tdre), 1);
    for (int i = 0; i < 3; i++) begin
      sck_in = 1'b0; repeat (6) @(negedge clk);
      sck_in = 1'b1; repeat (6) @(negedge clk);
    end
    cs_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 sd_oe active", 32'(sd_oe), 1);
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0; repeat (6) @(negedge clk);
      w = {w[30:0], sd};
      sck_in = 1'b1; repeat (6) @(negedge clk);
    end
    chk("R10 slave data", w & 32'hFF, 32'hB4);
    chk("R10 slave tend", 32'(tend), 1);
    cs_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 sd_oe released", 32'(sd_oe), 0);
    master = 1'b1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_master_frame(16'h00A5, 5'd8,  8,  "R3 8-bit");
    t_master_frame(16'hC3A5, 5'd16, 16, "R3 16-bit");
    t_master_frame(16'hF9B6, 5'd12, 12, "R3 12-bit upper bits dropped");
    t_master_frame(16'h5A96, 5'd3,  8,  "R3 clamp low");
    t_master_frame(16'h6E1D, 5'd20, 16, "R3 clamp high");
    t_chain();
    t_tend_clear();
    t_irq();
    t_lockout();
    t_oe_master();
    t_slave();
    summary();
    $finish;
  end
endmodule